// File: doc/BRIEF.md
# Memory Test Traffic Generator and Checker

This block drives test traffic into an external memory through a simple local request port. It starts only after the memory side reports that initialization is finished and that the controller is ready for user traffic. A pass writes a run of pseudo-random words to consecutive addresses, then reads those addresses back in the same order. Each returned word is checked against a value rebuilt by running the same pseudo-random generator again from its seed, so the written data is never stored.

For every returned word the block shows which byte lanes matched. It also keeps one sticky pass flag that drops on the first mismatch and stays low until reset. At the end of every pass it emits a one-cycle completion pulse and then starts the next pass at once. Read data is used only when the controller marks it valid, so the check works for any read latency.

The sequencer has five states. `ST_WAIT_CAL` moves to `ST_WRITE` when `cal_done` and `user_rdy` are both high. `ST_WRITE` moves to `ST_READ` when the last write is accepted. `ST_READ` moves to `ST_DRAIN` when the last read is accepted. `ST_DRAIN` moves to `ST_DONE` when the final read word returns. `ST_DONE` lasts one cycle and always moves back to `ST_WRITE`.

Top module: `memtest_gen`

## Requirements
- R1: While either `cal_done` or `user_rdy` is low, and no pass has started since reset, `req_wr` and `req_rd` stay low.
- R2: A pass begins with WORDS writes to addresses BASE_ADDR, BASE_ADDR+1, … in ascending order. The first data word is LFSR_SEED. Each later word is the previous word `s` shifted left by one, with bit 0 set to `s[31]^s[21]^s[1]^s[0]`.
- R3: A request is accepted on a clock edge where it is high and `cmd_ready` is high. While a request is pending and not yet accepted, `req_addr` and `req_wdata` hold their values.
- R4: After the last write is accepted, the block issues WORDS reads to the same addresses in the same order. Reads never overlap writes.
- R5: One cycle after each `rd_valid` cycle, bit i of `pnf_byte` is 1 exactly when bits [8i+7:8i] of `rd_data` equal the same bits of the expected word. The expected word is the LFSR sequence of R2, replayed from the seed. In cycles with no `rd_valid`, `pnf_byte` does not change. Reset sets it to all ones.
- R6: `pnf_all` is 1 after reset. It goes to 0 in the same cycle that `pnf_byte` shows any 0 bit. It then stays 0 until reset.
- R7: `pass_done` is a one-cycle pulse. It is raised only after all WORDS reads have returned. The next pass then starts with writes, and the data again begins from LFSR_SEED.
- R8: `req_wr` and `req_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_done | input | 1 | Memory initialization finished |
| user_rdy | input | 1 | Controller ready for user traffic |
| cmd_ready | input | 1 | Controller accepts a request this cycle |
| req_wr | output | 1 | Write request |
| req_rd | output | 1 | Read request |
| req_addr | output | ADDR_W | Request word address |
| req_wdata | output | DATA_W | Write data |
| rd_valid | input | 1 | Read data valid strobe |
| rd_data | input | DATA_W | Returned read data |
| pnf_byte | output | DATA_W/8 | Per-lane match flags for the latest returned word |
| pnf_all | output | 1 | Sticky overall pass flag (1 = pass) |
| pass_done | output | 1 | One-cycle pulse at the end of each pass |

## Verification
The assertions check on every cycle:
- request exclusivity;
- holding of a stalled request;
- the single-cycle completion pulse;
- stickiness of the pass flag and its agreement with the lane flags;
- lane flags staying unchanged when no valid read is present;
- silence before the start condition.

Only the bench scenarios can show the following:
- the actual LFSR data sequence and the address order;
- that reads follow every write of the same pass;
- that lane flags report the right lanes for a corrupted word under different latencies and ready patterns;
- that a new pass restarts from the seed.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_CAL = 3'd0,
        ST_WRITE    = 3'd1,
        ST_READ     = 3'd2,
        ST_DRAIN    = 3'd3,
        ST_DONE     = 3'd4
    } mt_state_e;

    localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/mt_lfsr.sv
module mt_lfsr #(
    parameter int unsigned      W    = 32,
    parameter logic [W-1:0]     TAPS = 32'h8020_0003,
    parameter logic [W-1:0]     SEED = 32'h1234_ABCD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] value
);

    logic feedback;

    // Fibonacci form: parity of the tapped bits enters at bit 0
    always_comb begin
        feedback = ^(value & TAPS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= SEED;
        end else if (load) begin
            value <= SEED;
        end else if (step) begin
            value <= {value[W-2:0], feedback};
        end
    end

endmodule

// File: rtl/mt_seq.sv
module mt_seq
    import memtest_pkg::*;
#(
    parameter int unsigned WORDS = 16,
    parameter int unsigned CW    = $clog2(WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cal_done,
    input  logic          user_rdy,
    input  logic          cmd_ready,
    input  logic          rd_valid,
    output logic          issue_wr,
    output logic          issue_rd,
    output logic          wr_step,
    output logic          wr_load,
    output logic          rd_load,
    output logic          chk_en,
    output logic          pass_done,
    output logic [CW-1:0] word_idx
);

    localparam logic [CW-1:0] LAST_IDX = CW'(WORDS - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(WORDS);

    mt_state_e     state;
    mt_state_e     state_nxt;
    logic [CW-1:0] iss_cnt;
    logic [CW-1:0] ret_cnt;
    logic          last_iss;
    logic          accept;
    logic          ret_full;

    always_comb begin
        last_iss = (iss_cnt == LAST_IDX);
        accept   = (issue_wr || issue_rd) && cmd_ready;
        ret_full = ((ret_cnt + CW'(chk_en)) == FULL_CNT);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT_CAL;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT_CAL: if (cal_done && user_rdy)  state_nxt = ST_WRITE;
            ST_WRITE:    if (cmd_ready && last_iss) state_nxt = ST_READ;
            ST_READ:     if (cmd_ready && last_iss) state_nxt = ST_DRAIN;
            ST_DRAIN:    if (ret_full)              state_nxt = ST_DONE;
            ST_DONE:                                state_nxt = ST_WRITE;
            default:                                state_nxt = ST_WAIT_CAL;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        issue_wr  = (state == ST_WRITE);
        issue_rd  = (state == ST_READ);
        wr_step   = issue_wr && cmd_ready;
        rd_load   = issue_wr && cmd_ready && last_iss;
        wr_load   = (state == ST_DONE);
        chk_en    = rd_valid && ((state == ST_READ) || (state == ST_DRAIN));
        pass_done = (state == ST_DONE);
        word_idx  = iss_cnt;
    end

    // Issue counter: shared by the write and read phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_cnt <= '0;
        end else if (accept) begin
            iss_cnt <= last_iss ? '0 : iss_cnt + 1'b1;
        end
    end

    // Return counter: counts read words that came back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_cnt <= '0;
        end else if (state == ST_DONE) begin
            ret_cnt <= '0;
        end else if (chk_en) begin
            ret_cnt <= ret_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mt_lane_cmp.sv
module mt_lane_cmp
    import memtest_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned LANES = DW / LANE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic [DW-1:0]    rd_data,
    input  logic [DW-1:0]    exp_data,
    output logic [LANES-1:0] pnf_byte,
    output logic             pnf_all
);

    logic [LANES-1:0] lane_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ok[g] =
            (rd_data[g*LANE_BITS +: LANE_BITS] == exp_data[g*LANE_BITS +: LANE_BITS]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnf_byte <= '1;
            pnf_all  <= 1'b1;
        end else if (chk_en) begin
            pnf_byte <= lane_ok;
            if (!(&lane_ok)) begin
                pnf_all <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/memtest_gen.sv
module memtest_gen
    import memtest_pkg::*;
#(
    parameter int unsigned          DATA_W    = 32,
    parameter int unsigned          ADDR_W    = 8,
    parameter int unsigned          WORDS     = 16,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = 8'h20,
    parameter logic [DATA_W-1:0]    LFSR_SEED = 32'h1234_ABCD,
    parameter logic [DATA_W-1:0]    LFSR_TAPS = 32'h8020_0003
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cal_done,
    input  logic                        user_rdy,
    input  logic                        cmd_ready,
    output logic                        req_wr,
    output logic                        req_rd,
    output logic [ADDR_W-1:0]           req_addr,
    output logic [DATA_W-1:0]           req_wdata,
    input  logic                        rd_valid,
    input  logic [DATA_W-1:0]           rd_data,
    output logic [DATA_W/LANE_BITS-1:0] pnf_byte,
    output logic                        pnf_all,
    output logic                        pass_done
);

    localparam int unsigned CW    = $clog2(WORDS + 1);
    localparam int unsigned LANES = DATA_W / LANE_BITS;

    logic              wr_step;
    logic              wr_load;
    logic              rd_load;
    logic              chk_en;
    logic [CW-1:0]     word_idx;
    logic [DATA_W-1:0] exp_word;

    mt_seq #(
        .WORDS (WORDS),
        .CW    (CW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_done  (cal_done),
        .user_rdy  (user_rdy),
        .cmd_ready (cmd_ready),
        .rd_valid  (rd_valid),
        .issue_wr  (req_wr),
        .issue_rd  (req_rd),
        .wr_step   (wr_step),
        .wr_load   (wr_load),
        .rd_load   (rd_load),
        .chk_en    (chk_en),
        .pass_done (pass_done),
        .word_idx  (word_idx)
    );

    // Write-side generator
    mt_lfsr #(
        .W    (DATA_W),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) u_wr_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_load),
        .step  (wr_step),
        .value (req_wdata)
    );

    // Expected-data generator: reloaded as the read phase begins
    mt_lfsr #(
        .W    (DATA_W),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) u_exp_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_load),
        .step  (chk_en),
        .value (exp_word)
    );

    mt_lane_cmp #(
        .DW    (DATA_W),
        .LANES (LANES)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_en   (chk_en),
        .rd_data  (rd_data),
        .exp_data (exp_word),
        .pnf_byte (pnf_byte),
        .pnf_all  (pnf_all)
    );

    assign req_addr = BASE_ADDR + ADDR_W'(word_idx);

endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 8,
    parameter int unsigned LN = DW / 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cal_done,
    input logic          user_rdy,
    input logic          cmd_ready,
    input logic          req_wr,
    input logic          req_rd,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] req_wdata,
    input logic          rd_valid,
    input logic [LN-1:0] pnf_byte,
    input logic          pnf_all,
    input logic          pass_done
);

    logic started;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else if (cal_done && user_rdy) begin
            started <= 1'b1;
        end
    end

    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (!req_wr && !req_rd));

    a_r3_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !cmd_ready) |=> (req_wr && $stable(req_addr) && $stable(req_wdata)));

    a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && !cmd_ready) |=> (req_rd && $stable(req_addr)));

    a_r5_no_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> $stable(pnf_byte));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !pnf_all |=> !pnf_all);

    a_r6_lane_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        !(&pnf_byte) |-> !pnf_all);

    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_wr && req_rd));

endmodule

bind memtest_gen mt_checker #(
    .DW (DATA_W),
    .AW (ADDR_W),
    .LN (DATA_W / 8)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_done  (cal_done),
    .user_rdy  (user_rdy),
    .cmd_ready (cmd_ready),
    .req_wr    (req_wr),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .pnf_byte  (pnf_byte),
    .pnf_all   (pnf_all),
    .pass_done (pass_done)
);

// File: tb/sim_memtest_gen.sv
module sim_memtest_gen;

    localparam int unsigned DW   = 32;
    localparam int unsigned AW   = 8;
    localparam int unsigned NW   = 16;
    localparam logic [7:0]  BASE = 8'h20;
    localparam logic [31:0] SEED = 32'h1234_ABCD;

    // case vector: {ready_mode[1:0], latency-1[2:0], corrupt}
    localparam int NCASE = 6;
    localparam logic [5:0] CASES [0:NCASE-1] = '{
        {2'd0, 3'd0, 1'b0},
        {2'd1, 3'd2, 1'b0},
        {2'd2, 3'd4, 1'b0},
        {2'd0, 3'd7, 1'b0},
        {2'd2, 3'd1, 1'b1},
        {2'd1, 3'd3, 1'b1}
    };

    logic          clk;
    logic          rst_n;
    logic          cal_done;
    logic          user_rdy;
    logic          cmd_ready;
    logic          req_wr;
    logic          req_rd;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [3:0]    pnf_byte;
    logic          pnf_all;
    logic          pass_done;

    int chk, fail, mchk, mfail;

    initial clk = 1'b0;
    always #10 clk = ~clk;

    memtest_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_done  (cal_done),
        .user_rdy  (user_rdy),
        .cmd_ready (cmd_ready),
        .req_wr    (req_wr),
        .req_rd    (req_rd),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .pnf_byte  (pnf_byte),
        .pnf_all   (pnf_all),
        .pass_done (pass_done)
    );

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // ---------------- memory model ----------------
    logic [1:0]    rmode;
    int            lat_cfg;
    logic          corrupt_cfg;
    logic [DW-1:0] mem [0:255];
    logic          pv [0:7];
    logic [DW-1:0] pd [0:7];
    logic          corrupt_arm;
    int            rd_idx;
    int            cyc;
    logic [DW-1:0] tmp;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                pv[i] <= 1'b0;
                pd[i] <= '0;
            end
            cmd_ready   <= 1'b0;
            corrupt_arm <= corrupt_cfg;
            rd_idx      <= 0;
            cyc         <= 0;
        end else begin
            cyc <= cyc + 1;
            case (rmode)
                2'd0:    cmd_ready <= 1'b1;
                2'd1:    cmd_ready <= ~cmd_ready;
                default: cmd_ready <= ((cyc % 3) != 0);
            endcase
            if (req_wr && cmd_ready) mem[req_addr] <= req_wdata;
            for (int i = 0; i < 7; i++) begin
                pv[i] <= pv[i+1];
                pd[i] <= pd[i+1];
            end
            pv[7] <= 1'b0;
            if (req_rd && cmd_ready) begin
                tmp = mem[req_addr];
                if (corrupt_arm && rd_idx == 5) begin
                    tmp[23:16] = tmp[23:16] ^ 8'hFF;
                    corrupt_arm <= 1'b0;
                end
                pv[lat_cfg-1] <= 1'b1;
                pd[lat_cfg-1] <= tmp;
                rd_idx <= (rd_idx == NW - 1) ? 0 : rd_idx + 1;
            end
        end
    end

    assign rd_valid = pv[0];
    assign rd_data  = pv[0] ? pd[0] : 32'hDEAD_BEEF;

    // ---------------- monitor ----------------
    int            wcnt, rcnt, retcnt, passes;
    logic [31:0]   mw, mr;
    logic          pend, exp_all, st_wr, st_rd, prev_done;
    logic [3:0]    exp_pb, last_pb;
    logic [AW-1:0] sa;
    logic [DW-1:0] sd;

    task automatic mcheck(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        mchk++;
        if (!ok) begin
            mfail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            wcnt = 0; rcnt = 0; retcnt = 0; passes = 0;
            mw = SEED; mr = SEED;
            pend = 1'b0; exp_all = 1'b1; st_wr = 1'b0; st_rd = 1'b0; prev_done = 1'b0;
            last_pb = 4'hF; exp_pb = 4'hF;
        end else begin
            if (pend) begin
                mcheck(pnf_byte == exp_pb, "R5 lane flags", 64'(pnf_byte), 64'(exp_pb));
                mcheck(pnf_all == exp_all, "R6 sticky flag", 64'(pnf_all), 64'(exp_all));
            end else begin
                mcheck(pnf_byte == last_pb, "R5 unchanged without valid", 64'(pnf_byte), 64'(last_pb));
            end
            last_pb = pnf_byte;
            if (st_wr) mcheck(req_wr && req_addr == sa && req_wdata == sd, "R3 write held",
                              64'(req_wdata), 64'(sd));
            if (st_rd) mcheck(req_rd && req_addr == sa, "R3 read held", 64'(req_addr), 64'(sa));
            st_wr = req_wr && !cmd_ready;
            st_rd = req_rd && !cmd_ready;
            sa = req_addr;
            sd = req_wdata;
            if (req_wr && cmd_ready) begin
                mcheck(rcnt == 0 && req_addr == BASE + AW'(wcnt), "R2 write address",
                       64'(req_addr), 64'(BASE + AW'(wcnt)));
                mcheck(req_wdata == mw, "R2 write data", 64'(req_wdata), 64'(mw));
                mw = lfsr_next(mw);
                wcnt++;
            end
            if (req_rd && cmd_ready) begin
                mcheck(wcnt == NW, "R4 reads after all writes", 64'(wcnt), 64'(NW));
                mcheck(req_addr == BASE + AW'(rcnt), "R4 read address",
                       64'(req_addr), 64'(BASE + AW'(rcnt)));
                rcnt++;
            end
            if (rd_valid) begin
                for (int b = 0; b < 4; b++) exp_pb[b] = (rd_data[8*b +: 8] == mr[8*b +: 8]);
                if (exp_pb != 4'hF) exp_all = 1'b0;
                mr = lfsr_next(mr);
                retcnt++;
                pend = 1'b1;
            end else begin
                pend = 1'b0;
            end
            if (pass_done) begin
                mcheck(!prev_done, "R7 single-cycle pulse", 64'(prev_done), 64'd0);
                mcheck(wcnt == NW && rcnt == NW && retcnt == NW, "R7 all reads returned",
                       64'(retcnt), 64'(NW));
                wcnt = 0; rcnt = 0; retcnt = 0;
                mw = SEED; mr = SEED;
                passes++;
            end
            prev_done = pass_done;
        end
    end

    // ---------------- directed flow ----------------
    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        chk++;
        if (!ok) begin
            fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000 && !ok; i++) begin
            @(negedge clk);
            if (pass_done) ok = 1'b1;
        end
    endtask

    initial begin
        #(20 * 150000);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", chk + mchk + 1, fail + mfail + 1);
        $finish;
    end

    initial begin
        bit ok;
        bit idle;
        chk = 0; fail = 0; mchk = 0; mfail = 0;
        rst_n = 1'b0; cal_done = 1'b0; user_rdy = 1'b0;
        rmode = 2'd0; lat_cfg = 2; corrupt_cfg = 1'b0;
        repeat (4) @(negedge clk);
        check(!req_wr && !req_rd && !pass_done, "R1 reset no request", 64'({req_wr, req_rd, pass_done}), 64'd0);
        check(pnf_byte == 4'hF, "R5 reset lane flags", 64'(pnf_byte), 64'hF);
        check(pnf_all == 1'b1, "R6 reset pass flag", 64'(pnf_all), 64'd1);
        rst_n = 1'b1;

        // R1: only one of the two start conditions present
        user_rdy = 1'b1;
        idle = 1'b1;
        repeat (20) begin @(negedge clk); if (req_wr || req_rd) idle = 1'b0; end
        check(idle, "R1 idle without cal_done", 64'(idle), 64'd1);
        cal_done = 1'b1; user_rdy = 1'b0;
        idle = 1'b1;
        repeat (10) begin @(negedge clk); if (req_wr || req_rd) idle = 1'b0; end
        check(idle, "R1 idle without user_rdy", 64'(idle), 64'd1);
        user_rdy = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(req_wr, "R2 write starts after both ready", 64'(req_wr), 64'd1);

        // table of traffic scenarios
        for (int c = 0; c < NCASE; c++) begin
            rst_n = 1'b0;
            rmode       = CASES[c][5:4];
            lat_cfg     = int'(CASES[c][3:1]) + 1;
            corrupt_cfg = CASES[c][0];
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            if (corrupt_cfg) begin
                ok = 1'b0;
                for (int i = 0; i < 3000 && !ok; i++) begin
                    @(negedge clk);
                    if (pnf_byte != 4'hF) ok = 1'b1;
                end
                check(ok && pnf_byte == 4'b1011, "R5 corrupted lane 2 flagged", 64'(pnf_byte), 64'hB);
                check(pnf_all == 1'b0, "R6 pass flag cleared", 64'(pnf_all), 64'd0);
            end
            wait_done(ok);
            check(ok, "R7 first pass completes", 64'(ok), 64'd1);
            wait_done(ok);
            check(ok, "R7 pass repeats", 64'(ok), 64'd1);
            @(negedge clk);
            check(passes == 2, "R7 pass count", 64'(passes), 64'd2);
            check(pnf_all == !corrupt_cfg, "R6 final pass flag", 64'(pnf_all), 64'(!corrupt_cfg));
            check(pnf_byte == 4'hF, "R5 last word clean", 64'(pnf_byte), 64'hF);
        end

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(pnf_all == 1'b1, "R6 reset restores pass flag", 64'(pnf_all), 64'd1);

        $display("  TB_RESULT checks=%0d failures=%0d", chk + mchk, fail + mfail);
        $finish;
    end

endmodule